// File: doc/BRIEF.md
# Edge/Level Interrupt Controller Single-Bank

This block collects up to 32 interrupt lines into two request outputs, a normal one and a fast one. Each line has its own configuration word. The word selects edge or level sensitivity, gives a 5-bit priority, and chooses which output the line is routed to. Inputs pass through a two-flop synchronizer. Edges are detected on the synchronized value. A pending bit is then latched for each line.

Each output has an arm flag. An armed output fires when an unmasked pending line is routed to it. When it fires, the output latches the code of the winning line and disarms. It stays asserted until software re-arms it through the control register. Software reads the winner code from one of two code registers. For an edge-sensitive line, that read also clears the line's pending bit.

All registers sit behind a simple word bus with an 8-bit byte address. Read data is registered.

Top module: `ilc_top`

## Requirements
- R1: After synchronous reset: both outputs are low, both arm flags are set, pending is 0, mask (0x04) is all ones, and every configuration word and both code registers read 0.
- R2: The configuration word for line n is at 0x1C + 4*n. Priority is in bits [6:2], sensitivity in bit 1 (0 = edge, 1 = level), and fast routing in bit 1's neighbour bit 0 (1 = fast output). Reads return the same layout, with all other bits 0.
- R3: An edge-sensitive line becomes pending only on an inactive-to-active change of its synchronized input, and stays pending after the input drops.
- R4: A level-sensitive line is pending while its synchronized input is high, and its pending bit clears when that input falls.
- R5: A write to 0x00 ANDs the pending bits with the written value. Bits of level-sensitive lines whose synchronized input is high are left set.
- R6: A mask bit of 1 at 0x04 blocks its line from both outputs. A mask write takes effect on the next evaluation, with no other action needed.
- R7: An output rises only while it is armed and some unmasked pending line is routed to it. On that edge it disarms and latches the winner code. Later arrivals do not change the code or the output.
- R8: The winner is the candidate with the smallest priority value. On a tie, the higher line number wins.
- R9: Reading 0x10 (normal) or 0x14 (fast) returns the latched code. If that line is edge-sensitive, the read clears its pending bit.
- R10: Writing control 0x18 with bit 0 (normal) or bit 1 (fast) set lowers that output on the capturing edge and re-arms it. If a candidate is present, the output rises again one edge later.
- R11: A write to 0x9C makes only the line of the lowest set data bit pending. Both 0x9C and 0x18 read as 0.
- R12: A rising input is pending after the third clock edge, counting the edge that first samples it. An armed, unmasked output rises on the fourth edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| irq_i | input | NLINES | Asynchronous interrupt lines, active high |
| addr_i | input | 8 | Register byte address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | DW | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | DW | Read data, valid the cycle after rd_en_i |
| irq_norm_o | output | 1 | Normal request output |
| irq_fast_o | output | 1 | Fast request output |

## Verification
Each wrong internal state has a visible effect at the ports:
- A corrupted arm flag shows up as an output that rises a second time without a control write, or that never comes back after one.
- A wrong pending bit shows up on the next read of 0x00.
- A wrong winner shows up in the code register read after the output rises.

The timing checks sit exactly on the cycle: the output rise four edges after an input change, the drop on the edge that captures a control write, and the rise again one edge later. An error of one register in the synchronizer or the arbiter therefore appears within a single cycle.

// File: rtl/ilc_pkg.sv
package ilc_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] A_PEND   = 8'h00;
  localparam logic [ADDR_W-1:0] A_MASK   = 8'h04;
  localparam logic [ADDR_W-1:0] A_CODE_N = 8'h10;
  localparam logic [ADDR_W-1:0] A_CODE_F = 8'h14;
  localparam logic [ADDR_W-1:0] A_CTRL   = 8'h18;
  localparam logic [ADDR_W-1:0] A_CFG0   = 8'h1C;
  localparam logic [ADDR_W-1:0] A_SWSET  = 8'h9C;

  localparam int CFG_ROUTE_BIT = 0;
  localparam int CFG_SENS_BIT  = 1;
  localparam int CFG_PRIO_LSB  = 2;

  typedef enum logic {OUT_NORM = 1'b0, OUT_FAST = 1'b1} out_sel_e;
endpackage

// File: rtl/ilc_sync.sv
module ilc_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st_q <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) st_q[s] <= st_q[s-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/ilc_prio.sv
module ilc_prio #(
  parameter int N  = 32,
  parameter int PW = 5,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]         cand_i,
  input  logic [N-1:0][PW-1:0] prio_i,
  output logic                 vld_o,
  output logic [IW-1:0]        idx_o
);
  logic [PW-1:0] best;

  // Ascending scan with <= : smallest value wins, ties go to the higher line.
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    best  = '1;
    for (int i = 0; i < N; i++) begin
      if (cand_i[i] && (prio_i[i] <= best)) begin
        vld_o = 1'b1;
        best  = prio_i[i];
        idx_o = IW'(i);
      end
    end
  end

  // R8: a reported winner must be one of the candidates
  always_comb begin
    a_r8_winner_is_candidate: assert (!vld_o || cand_i[idx_o]);
  end
endmodule

// File: rtl/ilc_top.sv
module ilc_top
  import ilc_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int PW     = 5,
  parameter int DW     = 32,
  parameter int SYNC   = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [NLINES-1:0] irq_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic              rd_en_i,
  output logic [DW-1:0]     rd_data_o,
  output logic              irq_norm_o,
  output logic              irq_fast_o
);
  localparam int IW    = (NLINES > 1) ? $clog2(NLINES) : 1;
  localparam int CFG_W = PW + 2;
  localparam int NOUT  = 2;

  // ---------------- input synchronizer and edge detect (R12, R3, R4)
  logic [NLINES-1:0] lvl, lvl_d;
  ilc_sync #(.W(NLINES), .STAGES(SYNC)) u_sync (
    .clk_i(clk_i), .rst_i(rst_i), .d_i(irq_i), .q_o(lvl)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) lvl_d <= '0;
    else       lvl_d <= lvl;
  end

  logic [NLINES-1:0] rise, fall;
  assign rise = lvl & ~lvl_d;
  assign fall = ~lvl & lvl_d;

  // ---------------- address decode
  logic [ADDR_W-1:0] cfg_off;
  logic              cfg_hit;
  logic [IW-1:0]     cfg_idx;
  assign cfg_off = addr_i - A_CFG0;
  assign cfg_hit = (addr_i >= A_CFG0) && (cfg_off[1:0] == 2'b00) &&
                   (32'(cfg_off[ADDR_W-1:2]) < NLINES);
  assign cfg_idx = IW'(cfg_off[ADDR_W-1:2]);

  logic wr_pend, wr_mask, wr_ctrl, wr_swset, wr_cfg;
  assign wr_pend  = wr_en_i && (addr_i == A_PEND);
  assign wr_mask  = wr_en_i && (addr_i == A_MASK);
  assign wr_ctrl  = wr_en_i && (addr_i == A_CTRL);
  assign wr_swset = wr_en_i && (addr_i == A_SWSET);
  assign wr_cfg   = wr_en_i && cfg_hit;

  logic [NOUT-1:0] rd_code;
  assign rd_code[OUT_NORM] = rd_en_i && (addr_i == A_CODE_N);
  assign rd_code[OUT_FAST] = rd_en_i && (addr_i == A_CODE_F);

  // ---------------- per-line state
  logic [NLINES-1:0][PW-1:0] prio_q;
  logic [NLINES-1:0]         sens_q, route_q, mask_q, pend_q, pend_nx;
  logic [NOUT-1:0]           arm_q, out_q;
  logic [NOUT-1:0][IW-1:0]   code_q;

  // Software set: only the lowest set data bit (R11)
  logic [NLINES-1:0] sw_data, sw_bit;
  assign sw_data = wr_data_i[NLINES-1:0];
  assign sw_bit  = wr_swset ? (sw_data & (~sw_data + NLINES'(1))) : '0;

  // Code read clears an edge line's pending bit (R9)
  logic [NLINES-1:0] rd_clr;
  always_comb begin
    rd_clr = '0;
    for (int k = 0; k < NOUT; k++) begin
      if (rd_code[k] && !sens_q[code_q[k]]) rd_clr[code_q[k]] = 1'b1;
    end
  end

  // AND-clear that held level lines resist (R5)
  logic [NLINES-1:0] and_keep;
  assign and_keep = wr_pend ? (sw_data | (lvl & sens_q)) : '1;

  assign pend_nx = ((pend_q & and_keep) & ~(fall & sens_q) & ~rd_clr)
                 | (rise & ~sens_q) | (lvl & sens_q) | sw_bit;

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        prio_q[g]  <= '0;
        sens_q[g]  <= 1'b0;
        route_q[g] <= 1'b0;
        mask_q[g]  <= 1'b1;
        pend_q[g]  <= 1'b0;
      end else begin
        pend_q[g] <= pend_nx[g];
        if (wr_mask) mask_q[g] <= wr_data_i[g];
        if (wr_cfg && (cfg_idx == IW'(g))) begin
          prio_q[g]  <= wr_data_i[CFG_PRIO_LSB +: PW];
          sens_q[g]  <= wr_data_i[CFG_SENS_BIT];
          route_q[g] <= wr_data_i[CFG_ROUTE_BIT];
        end
      end
    end
  end

  // ---------------- arbitration per output (R7, R8, R10)
  logic [NOUT-1:0][NLINES-1:0] cand;
  logic [NOUT-1:0]             win_vld;
  logic [NOUT-1:0][IW-1:0]     win_idx;

  for (genvar k = 0; k < NOUT; k++) begin : g_out
    assign cand[k] = pend_q & ~mask_q & ((k == int'(OUT_FAST)) ? route_q : ~route_q);

    ilc_prio #(.N(NLINES), .PW(PW), .IW(IW)) u_prio (
      .cand_i(cand[k]), .prio_i(prio_q), .vld_o(win_vld[k]), .idx_o(win_idx[k])
    );

    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        arm_q[k]  <= 1'b1;
        out_q[k]  <= 1'b0;
        code_q[k] <= '0;
      end else if (wr_ctrl && wr_data_i[k]) begin
        arm_q[k] <= 1'b1;
        out_q[k] <= 1'b0;
      end else if (arm_q[k] && win_vld[k]) begin
        arm_q[k]  <= 1'b0;
        out_q[k]  <= 1'b1;
        code_q[k] <= win_idx[k];
      end
    end
  end

  assign irq_norm_o = out_q[OUT_NORM];
  assign irq_fast_o = out_q[OUT_FAST];

  // ---------------- registered read port
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rd_data_o <= '0;
    end else if (rd_en_i) begin
      if (cfg_hit) begin
        rd_data_o <= DW'({prio_q[cfg_idx], sens_q[cfg_idx], route_q[cfg_idx]});
      end else begin
        case (addr_i)
          A_PEND:   rd_data_o <= DW'(pend_q);
          A_MASK:   rd_data_o <= DW'(mask_q);
          A_CODE_N: rd_data_o <= DW'(code_q[OUT_NORM]);
          A_CODE_F: rd_data_o <= DW'(code_q[OUT_FAST]);
          default:  rd_data_o <= '0;
        endcase
      end
    end
  end

  // ---------------- assertions
  // R7: an output only rises from the armed state
  a_r7_rise_needs_arm: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(irq_norm_o) |-> $past(arm_q[OUT_NORM]));

  // R7: a rise needs an unmasked pending line routed to that output
  a_r7_rise_needs_line: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(irq_fast_o) |-> $past(|(pend_q & ~mask_q & route_q)));

  // R10: a control write lowers the output and re-arms it
  a_r10_ctrl_drops: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_ctrl && wr_data_i[0]) |=> (!irq_norm_o && arm_q[OUT_NORM]));

  // R4/R5: a held level line cannot lose its pending bit
  a_r4_level_held: assert property (@(posedge clk_i) disable iff (rst_i)
    ((pend_q & $past(sens_q & lvl)) == $past(sens_q & lvl)));

  // R6: a masked line never makes the normal output rise alone
  a_r6_mask_blocks: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(irq_norm_o) |-> $past(|(pend_q & ~mask_q)));
endmodule

// File: tb/ilc_top_test.sv
module ilc_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  // {lineA, prioA, lineB, prioB, expected winner}
  localparam logic [24:0] VEC [NV] = '{
    {5'd3,  5'd4,  5'd10, 5'd2,  5'd10},
    {5'd3,  5'd2,  5'd10, 5'd4,  5'd3},
    {5'd5,  5'd7,  5'd20, 5'd7,  5'd20},
    {5'd31, 5'd0,  5'd0,  5'd0,  5'd31},
    {5'd0,  5'd0,  5'd31, 5'd31, 5'd0},
    {5'd12, 5'd30, 5'd13, 5'd31, 5'd12}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq = '0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_n, irq_f;
  int checks = 0, failures = 0;
  logic [31:0] v;

  ilc_top uut (
    .clk_i(clk), .rst_i(rst), .irq_i(irq), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wdata), .rd_en_i(rd_en), .rd_data_o(rdata),
    .irq_norm_o(irq_n), .irq_fast_o(irq_f)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; irq = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic do_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic pulse(int line);
    @(negedge clk); irq[line] = 1'b1;
    repeat (3) @(negedge clk);
    irq[line] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    chk("R1 norm low", 32'(irq_n), 0);
    chk("R1 fast low", 32'(irq_f), 0);
    do_read(8'h04, v); chk("R1 mask", v, 32'hFFFF_FFFF);
    do_read(8'h00, v); chk("R1 pending", v, 0);
    do_read(8'h1C, v); chk("R1 cfg0", v, 0);
    do_read(8'h10, v); chk("R1 code", v, 0);

    // R8 winner table
    for (int n = 0; n < NV; n++) begin
      logic [4:0] la, pa, lb, pb, ex;
      {la, pa, lb, pb, ex} = VEC[n];
      do_reset();
      do_write(8'h1C + 8'(4 * la), 32'({pa, 2'b10}));
      do_write(8'h1C + 8'(4 * lb), 32'({pb, 2'b10}));
      do_write(8'h04, 32'h0);
      @(negedge clk); irq[la] = 1'b1; irq[lb] = 1'b1;
      repeat (6) @(negedge clk);
      chk("R8 out", 32'(irq_n), 1);
      do_read(8'h10, v); chk("R8 winner", v, 32'(ex));
      irq = '0;
    end

    // R12 latency, R3 edge hold, R9 read clear
    do_reset();
    do_write(8'h04, 32'h0);
    @(negedge clk); irq[1] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12 not yet", 32'(irq_n), 0);
    @(negedge clk);
    chk("R12 rise", 32'(irq_n), 1);
    irq[1] = 1'b0;
    repeat (5) @(negedge clk);
    do_read(8'h00, v); chk("R3 edge kept", v, 32'h2);
    do_read(8'h10, v); chk("R9 code", v, 1);
    do_read(8'h00, v); chk("R9 cleared", v, 0);

    // R7 latched code, R10 re-arm
    pulse(6);
    chk("R7 still high", 32'(irq_n), 1);
    do_read(8'h10, v); chk("R7 code held", v, 1);
    do_write(8'h18, 32'h1);
    chk("R10 drop", 32'(irq_n), 0);
    @(negedge clk);
    chk("R10 re-rise", 32'(irq_n), 1);
    do_read(8'h10, v); chk("R10 new code", v, 6);

    // R4, R5 level
    do_reset();
    do_write(8'h38, 32'h2);
    do_write(8'h04, 32'h0);
    @(negedge clk); irq[7] = 1'b1;
    repeat (6) @(negedge clk);
    do_read(8'h00, v); chk("R4 level pend", v, 32'h80);
    do_write(8'h00, 32'h0);
    do_read(8'h00, v); chk("R5 held level", v, 32'h80);
    irq[7] = 1'b0;
    repeat (5) @(negedge clk);
    do_read(8'h00, v); chk("R4 level cleared", v, 0);
    pulse(2);
    do_read(8'h00, v); chk("R5 edge set", v, 32'h4);
    do_write(8'h00, 32'hFFFF_FFFB);
    do_read(8'h00, v); chk("R5 edge cleared", v, 0);

    // R6 mask
    do_reset();
    pulse(4);
    chk("R6 masked", 32'(irq_n), 0);
    do_read(8'h00, v); chk("R6 pend", v, 32'h10);
    do_write(8'h04, 32'hFFFF_FFEF);
    repeat (2) @(negedge clk);
    chk("R6 unmask", 32'(irq_n), 1);

    // R2 fast routing and config layout
    do_reset();
    do_write(8'h1C + 8'(4 * 9), 32'h1);
    do_write(8'h04, 32'h0);
    pulse(9);
    chk("R2 fast high", 32'(irq_f), 1);
    chk("R2 norm low", 32'(irq_n), 0);
    do_read(8'h14, v); chk("R9 fast code", v, 9);
    do_write(8'h18, 32'h2);
    repeat (2) @(negedge clk);
    chk("R10 fast drop", 32'(irq_f), 0);
    do_write(8'h6C, 32'hFFFF_FFFF);
    do_read(8'h6C, v); chk("R2 cfg readback", v, 32'h7F);

    // R11 software set
    do_reset();
    do_write(8'h9C, 32'h0000_0A00);
    do_read(8'h00, v); chk("R11 lowest only", v, 32'h200);
    do_read(8'h9C, v); chk("R11 swset reads 0", v, 0);
    do_read(8'h18, v); chk("R11 ctrl reads 0", v, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule